// File: doc/BRIEF.md
# Packed Bidirectional Saturating Shifter

This block shifts every lane of a 64-bit packed operand by one shared signed amount. The operand is treated as eight signed bytes or as four signed halfwords, chosen by a mode input. If the shift amount is zero or positive, each lane is shifted left logically. A left-shifted lane that no longer fits its signed range is clamped to the nearest signed limit. If the amount is negative, each lane is shifted right arithmetically by the magnitude of the amount.

The amount is a small two's-complement field at the bottom of a 32-bit control word. The field is four bits wide for bytes and five bits wide for halfwords. The most negative field value is treated as the largest legal right shift. The result is registered and appears one cycle after a valid request. It comes with a per-operation overflow flag and a sticky overflow bit that software-side logic can clear.

Top module: `simd_sat_shifter`

## Requirements
- R1: One clock edge after the edge that samples `in_valid` high, `out_valid` is 1 and `data_out`/`ovf` carry that request's result. After an edge with `in_valid` low, `out_valid` is 0 and `data_out` and `ovf` keep their previous values.
- R2: When `half_mode` is 0, lane i is bits [8i+7:8i] for i = 0..7. When `half_mode` is 1, lane i is bits [16i+15:16i] for i = 0..3. Lanes are computed independently.
- R3: In byte mode the amount is `shift_ctrl[3:0]`, read as two's complement (-8..7). In halfword mode the amount is `shift_ctrl[4:0]`, read as two's complement (-16..15). No other control bit affects any output.
- R4: A positive amount k shifts each lane left by k, filling the low end with zeros, whenever the lane's value times 2^k fits the lane's signed range.
- R5: A negative amount -k shifts each lane right by k, filling from the top with copies of the lane's sign bit.
- R6: A byte amount of -8 (field 4'h8) gives the same result as -7. A halfword amount of -16 (field 5'h10) gives the same result as -15.
- R7: A left-shifted lane whose exact value exceeds the signed maximum becomes 0x7F (byte) or 0x7FFF (halfword), and `ovf` is 1.
- R8: A left-shifted lane whose exact value is below the signed minimum becomes 0x80 (byte) or 0x8000 (halfword), and `ovf` is 1.
- R9: An amount of zero returns every lane unchanged, with `ovf` 0.
- R10: A negative amount never sets `ovf`.
- R11: `ovf` is the OR of the saturation events of all lanes of the request. A single clamped lane sets it, and the other lanes are unaffected.
- R12: `ovf_sticky` sets on the edge that registers a request with overflow. It clears on an edge with `sticky_clr` high, unless that same edge registers an overflowing request, in which case it is set.
- R13: While `rst_n` is low, `data_out`, `out_valid`, `ovf` and `ovf_sticky` are 0. Reset release takes effect two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| half_mode | input | 1 | 0: eight byte lanes, 1: four halfword lanes |
| data_in | input | 64 | Packed operand |
| shift_ctrl | input | 32 | Control word holding the signed amount field |
| sticky_clr | input | 1 | Clears the sticky overflow bit |
| out_valid | output | 1 | Registered result valid |
| data_out | output | 64 | Registered shifted result |
| ovf | output | 1 | Overflow of the last registered request |
| ovf_sticky | output | 1 | Accumulated overflow since last clear |

## Verification
The hardest cases to reach from the ports are the boundaries where a left shift just fits or just misses the signed range. Examples are -1 shifted left by 7 in a byte, which stays exactly at the minimum, and lanes whose clamping depends on a single bit below the sign. Another is an overflow that lands on the same edge as a sticky clear. Directed requests place such values in single lanes next to lanes that fit. A long stream of random operands and control words follows, mixed with idle and clear cycles, and is compared each clock against a behavioural integer model.

// File: rtl/simd_shift_pkg.sv
package simd_shift_pkg;
  localparam int DATA_W = 64;
  localparam int CTRL_W = 32;

  typedef enum logic {
    LANE_B8  = 1'b0,
    LANE_H16 = 1'b1
  } lane_mode_e;
endpackage

// File: rtl/shift_amt_decode.sv
// Turns a signed amount field into a direction and an unsigned magnitude,
// folding the most negative code onto the largest legal right shift.
module shift_amt_decode #(
  parameter int W  = 8,
  localparam int AW = $clog2(W),
  localparam int FW = AW + 1
) (
  input  logic [FW-1:0] fld,
  output logic          shl,
  output logic [AW-1:0] amt
);
  logic [FW-1:0] mag;

  always_comb begin
    shl = ~fld[FW-1];
    mag = fld[FW-1] ? (~fld + 1'b1) : fld;
    if (fld[FW-1] && (mag == FW'(W))) amt = AW'(W - 1);
    else                              amt = mag[AW-1:0];
  end
endmodule

// File: rtl/sat_shift_lane.sv
// One lane: left shift with signed clamping, or arithmetic right shift.
module sat_shift_lane #(
  parameter int W  = 8,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  x,
  input  logic          shl,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  y,
  output logic          sat
);
  logic [2*W-1:0] wide;
  logic [W:0]     upper;
  logic           fits;

  always_comb begin
    wide  = {{W{x[W-1]}}, x} << amt;
    upper = wide[2*W-1:W-1];
    fits  = (upper == '0) || (upper == '1);
    if (shl) begin
      if (fits) begin
        y   = wide[W-1:0];
        sat = 1'b0;
      end else begin
        y   = x[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        sat = 1'b1;
      end
    end else begin
      y   = W'($signed(x) >>> amt);
      sat = 1'b0;
    end
  end
endmodule

// File: rtl/simd_sat_shifter.sv
module simd_sat_shifter
  import simd_shift_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CTRL_W,
  parameter int BW = 8,
  parameter int HW = 16,
  localparam int NB  = DW / BW,
  localparam int NH  = DW / HW,
  localparam int BAW = $clog2(BW),
  localparam int HAW = $clog2(HW),
  localparam int BFW = BAW + 1,
  localparam int HFW = HAW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          half_mode,
  input  logic [DW-1:0] data_in,
  input  logic [CW-1:0] shift_ctrl,
  input  logic          sticky_clr,
  output logic          out_valid,
  output logic [DW-1:0] data_out,
  output logic          ovf,
  output logic          ovf_sticky
);
  // reset synchroniser: asserts asynchronously, releases on the clock
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  lane_mode_e mode;
  assign mode = lane_mode_e'(half_mode);

  logic unused_ctrl_bits;
  assign unused_ctrl_bits = ^shift_ctrl[CW-1:HFW];

  logic           b_shl, h_shl;
  logic [BAW-1:0] b_amt;
  logic [HAW-1:0] h_amt;

  shift_amt_decode #(.W(BW)) u_dec_b (
    .fld (shift_ctrl[BFW-1:0]),
    .shl (b_shl),
    .amt (b_amt)
  );

  shift_amt_decode #(.W(HW)) u_dec_h (
    .fld (shift_ctrl[HFW-1:0]),
    .shl (h_shl),
    .amt (h_amt)
  );

  logic [DW-1:0] b_res, h_res;
  logic [NB-1:0] b_sat;
  logic [NH-1:0] h_sat;

  for (genvar gb = 0; gb < NB; gb++) begin : g_blane
    sat_shift_lane #(.W(BW)) u_lane (
      .x   (data_in[gb*BW +: BW]),
      .shl (b_shl),
      .amt (b_amt),
      .y   (b_res[gb*BW +: BW]),
      .sat (b_sat[gb])
    );
  end

  for (genvar gh = 0; gh < NH; gh++) begin : g_hlane
    sat_shift_lane #(.W(HW)) u_lane (
      .x   (data_in[gh*HW +: HW]),
      .shl (h_shl),
      .amt (h_amt),
      .y   (h_res[gh*HW +: HW]),
      .sat (h_sat[gh])
    );
  end

  logic [DW-1:0] res_c;
  logic          ovf_c;

  always_comb begin
    if (mode == LANE_H16) begin
      res_c = h_res;
      ovf_c = |h_sat;
    end else begin
      res_c = b_res;
      ovf_c = |b_sat;
    end
  end

  // next-state logic
  logic          res_en;
  logic [DW-1:0] data_d;
  logic          ovf_d, sticky_d, valid_d;

  always_comb begin
    res_en   = in_valid;
    valid_d  = in_valid;
    data_d   = res_en ? res_c : data_out;
    ovf_d    = res_en ? ovf_c : ovf;
    sticky_d = (ovf_sticky & ~sticky_clr) | (in_valid & ovf_c);
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid  <= 1'b0;
      data_out   <= '0;
      ovf        <= 1'b0;
      ovf_sticky <= 1'b0;
    end else begin
      out_valid  <= valid_d;
      ovf_sticky <= sticky_d;
      if (res_en) begin
        data_out <= data_d;
        ovf      <= ovf_d;
      end
    end
  end

  // assertions
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid);

  p_idle_holds_r1: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> ($stable(data_out) && $stable(ovf) && !out_valid));

  p_zero_passes_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && (half_mode ? (shift_ctrl[HFW-1:0] == '0) : (shift_ctrl[BFW-1:0] == '0)))
      |=> (data_out == $past(data_in) && !ovf));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && (half_mode ? shift_ctrl[HFW-1] : shift_ctrl[BFW-1])) |=> !ovf);

  p_sticky_covers_r12: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && ovf) |-> ovf_sticky);

  p_sticky_clears_r12: assert property (@(posedge clk) disable iff (!rst_q)
    (sticky_clr && !in_valid) |=> !ovf_sticky);
endmodule

// File: tb/test_simd_sat_shifter.sv
module test_simd_sat_shifter;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, in_valid, half_mode, sticky_clr;
  logic [63:0] data_in;
  logic [31:0] shift_ctrl;
  logic        out_valid, ovf, ovf_sticky;
  logic [63:0] data_out;

  simd_sat_shifter i_simd_sat_shifter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .half_mode(half_mode),
    .data_in(data_in), .shift_ctrl(shift_ctrl), .sticky_clr(sticky_clr),
    .out_valid(out_valid), .data_out(data_out), .ovf(ovf), .ovf_sticky(ovf_sticky)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [63:0] exp_out;
  bit exp_valid, exp_ovf, exp_sticky;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic void ref_op(input bit hm, input logic [63:0] d, input logic [31:0] c,
                                 output logic [63:0] r, output bit o);
    int w, n, f;
    longint lim, mask;
    w = hm ? 16 : 8;
    n = 64 / w;
    lim = longint'(1) << (w - 1);
    mask = (longint'(1) << w) - 1;
    f = int'(c) & (2 * w - 1);
    if (f >= w) f -= 2 * w;
    r = '0;
    o = 0;
    for (int i = 0; i < n; i++) begin
      longint v, t;
      int s;
      v = longint'((d >> (i * w)) & 64'(mask));
      if (v >= lim) v -= 2 * lim;
      if (f < 0) begin
        s = -f;
        if (s == w) s = w - 1;
        t = v >>> s;
      end else begin
        t = v * (longint'(1) << f);
        if (t > lim - 1) begin t = lim - 1; o = 1; end
        else if (t < -lim) begin t = -lim; o = 1; end
      end
      r |= (64'(t) & 64'(mask)) << (i * w);
    end
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic step(input string tag, input bit v, input bit hm, input logic [63:0] d,
                      input logic [31:0] c, input bit clr);
    logic [63:0] r;
    bit o;
    in_valid = v; half_mode = hm; data_in = d; shift_ctrl = c; sticky_clr = clr;
    ref_op(hm, d, c, r, o);
    exp_sticky = (exp_sticky && !clr) || (v && o);
    exp_valid = v;
    if (v) begin exp_out = r; exp_ovf = o; end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "data_out", data_out, exp_out);
    chk(tag, "out_valid", 64'(out_valid), 64'(exp_valid));
    chk(tag, "ovf", 64'(ovf), 64'(exp_ovf));
    chk(tag, "ovf_sticky", 64'(ovf_sticky), 64'(exp_sticky));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL R1 watchdog: actual hung expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; in_valid = 0; half_mode = 0; data_in = '0; shift_ctrl = '0; sticky_clr = 0;
    exp_out = '0; exp_valid = 0; exp_ovf = 0; exp_sticky = 0;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13", "data_out", data_out, 64'h0);
    chk("R13", "out_valid", 64'(out_valid), 64'h0);
    chk("R13", "ovf", 64'(ovf), 64'h0);
    chk("R13", "ovf_sticky", 64'(ovf_sticky), 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    step("R9",  1, 0, 64'h80FF7F0112345678, 32'h0, 0);
    step("R9",  1, 1, 64'h8000FFFF7FFF1234, 32'h0, 0);
    step("R4",  1, 0, 64'h10F0E0E1_01020304, 32'h2, 0);
    step("R4",  1, 0, 64'hFF00FF01_0000FF00, 32'h7, 0);
    step("R7",  1, 0, 64'h4001020340010203, 32'h1, 0);
    step("R12", 0, 0, 64'h0, 32'h0, 0);
    step("R12", 0, 0, 64'h0, 32'h0, 1);
    step("R8",  1, 0, 64'h81010101C0FEFE7E, 32'h1, 0);
    step("R11", 1, 0, 64'h0102030420050607, 32'h2, 1);
    step("R5",  1, 0, 64'h807FF001FE1081C3, 32'hE, 1);
    step("R10", 1, 0, 64'h8080808080808080, 32'h9, 0);
    step("R6",  1, 0, 64'h807F01FFC0403FE0, 32'h8, 0);
    step("R6",  1, 0, 64'h807F01FFC0403FE0, 32'h9, 0);
    step("R6",  1, 1, 64'h80007FFFC0004000, 32'h10, 0);
    step("R6",  1, 1, 64'h80007FFFC0004000, 32'h11, 0);
    step("R3",  1, 0, 64'h0102030405060708, 32'hFFFFFFF1, 0);
    step("R3",  1, 1, 64'h0102030405060708, 32'hABCDEF03, 0);
    step("R2",  1, 1, 64'h4000C0001FFF8001, 32'h1, 0);
    step("R10", 1, 1, 64'h8000FFFF7FFF0001, 32'h1F, 0);
    step("R1",  0, 1, 64'hDEADBEEFDEADBEEF, 32'h5, 0);
    step("R1",  0, 0, 64'h1111111111111111, 32'h1, 0);
    step("R12", 1, 1, 64'h7FFF000000000000, 32'h4, 1);
    step("R12", 0, 0, 64'h0, 32'h0, 1);

    for (int k = 0; k < 600; k++) begin
      bit v, hm, clr;
      logic [63:0] d;
      logic [31:0] c;
      v = ($urandom_range(0, 7) != 0);
      hm = $urandom_range(0, 1);
      clr = ($urandom_range(0, 9) == 0);
      d = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) d = d >> $urandom_range(0, 60);
      c = $urandom;
      step("R2", v, hm, d, c, clr);
    end
    summary();
  end
endmodule